// File: doc/BRIEF.md
# Transmit Frame Unpacker with Byte Alignment

This block sits between a host that writes transmit frames as 32-bit words and a byte-wide transmitter. The host first stores every word of a frame in a data FIFO. It then writes one command word into a command FIFO. The command word gives the frame's length in bytes and the byte lane where the frame's first byte sits inside the first word. The unpacker takes commands in order. For each one it sends exactly the frame's bytes on a ready/valid byte stream and marks the first and last bytes. Pad bytes in front of the frame in the first word, and fill bytes after it in the last word, are consumed but never sent.

The host uses the data-FIFO word count to check for free space before it writes a frame. A programmable almost-empty level gives a status flag and a one-cycle event, which the host can use to restart a stalled transmit queue. A write to a full data FIFO is dropped and sets a sticky overflow flag. A flush input empties both FIFOs and abandons any frame in progress.

Top module: `tx_frame_unpacker`

## Requirements
- R1: A command word carries the byte length in bits 15:0 and the first-byte lane in bits 17:16. Each frame consumes exactly floor((length + lane + 3) / 4) data words, so the data-FIFO count returns to zero once the frame has been sent.
- R2: Bytes are taken least-significant lane first (lane k is word bits 8k+7:8k). Output starts at the command's lane in the first word and stops after exactly `length` bytes. Lanes before the start and after the end are never sent.
- R3: `outStart` is high with the first byte of each frame and `outEnd` is high with its last byte. Both are low with every other byte.
- R4: While `outValid` is high and `outReady` is low, the byte, start and end outputs do not change and `outValid` stays high.
- R5: Frames are sent in command order. Data words already in the FIFO produce no output until their command has been written.
- R6: A command with length 0 consumes its floor((lane + 3) / 4) words and sends no bytes.
- R7: `dataWordCount` equals the number of words held in the data FIFO. It changes by at most one per cycle, except on a flush.
- R8: `almostEmpty` is high exactly when `dataWordCount` is at or below `aeThresh`. `aeEvent` pulses for one cycle when the count moves from above the threshold to at or below it.
- R9: A data write while the FIFO holds `DATA_DEPTH` words is dropped and sets `dataOverflow`. The flag stays set until a flush or reset.
- R10: A flush empties both FIFOs, clears `dataOverflow` and abandons the current frame. In the next cycle `outValid` is low and the count is zero, and a later frame is sent correctly.
- R11: After reset, the count is zero, `outValid` and `dataOverflow` are low and `almostEmpty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty both FIFOs and abandon the current frame |
| dataWrEn | input | 1 | Push `dataWrWord` into the data FIFO |
| dataWrWord | input | 32 | Frame data word, lane 0 in bits 7:0 |
| cmdWrEn | input | 1 | Push `cmdWrWord` into the command FIFO |
| cmdWrWord | input | 18 | Bits 15:0 length in bytes, bits 17:16 first-byte lane |
| aeThresh | input | clog2(DATA_DEPTH+1) | Almost-empty level in words |
| dataWordCount | output | clog2(DATA_DEPTH+1) | Words held in the data FIFO |
| almostEmpty | output | 1 | Count at or below `aeThresh` |
| aeEvent | output | 1 | One-cycle pulse when the count falls to or below the threshold |
| dataOverflow | output | 1 | Sticky flag: a data write was dropped because the FIFO was full |
| outValid | output | 1 | Output byte is valid |
| outReady | input | 1 | Sink accepts the byte |
| outByte | output | 8 | Frame byte |
| outStart | output | 1 | First byte of a frame |
| outEnd | output | 1 | Last byte of a frame |

## Verification
Most internal faults in this block reach the ports within a frame's length. A wrong lane counter shows as a bad byte at the first lane wrap. A wrong byte counter shows as a missing or misplaced end marker. A pop at the wrong time leaves a non-zero word count once the frame ends, and the next frame then starts with stale data. The bench therefore sweeps every start lane against a range of lengths that crosses one to four words. It checks every byte and both markers under a stalling sink, and it checks the word count before and after each frame. Threshold and overflow faults appear on the same cycle as the count change that causes them, so the bench checks them right after each push or drain.

// File: rtl/txu_pkg.sv
package txu_pkg;
  localparam int LEN_W = 16;
  localparam int LANE_W = 2;
  localparam int CMD_W = LEN_W + LANE_W;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              cmdPop;
    logic              dataPop;
    logic [LANE_W-1:0] byteSel;
  } txuStrobe_t;

  typedef struct packed {
    logic             cmdAvail;
    logic             dataAvail;
    logic [LEN_W-1:0] cmdLen;
    logic [LANE_W-1:0] cmdLane;
  } txuStatus_t;
endpackage

// File: rtl/txu_fifo.sv
module txu_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 1024,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doWr, doRd;

  assign doWr = wrEn && (count != CNT_W'(DEPTH)) && !flush;
  assign doRd = rdEn && (count != '0) && !flush;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txu_datapath.sv
module txu_datapath
  import txu_pkg::*;
#(
  parameter int DATA_DEPTH = 1024,
  parameter int CMD_DEPTH = 16,
  localparam int CNT_W = $clog2(DATA_DEPTH + 1),
  localparam int CCNT_W = $clog2(CMD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              dataWrEn,
  input  logic [WORD_W-1:0] dataWrWord,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrWord,
  input  logic [CNT_W-1:0]  aeThresh,
  input  txuStrobe_t        strobe,
  output txuStatus_t        status,
  output logic [7:0]        outByte,
  output logic [CNT_W-1:0]  dataWordCount,
  output logic              almostEmpty,
  output logic              aeEvent,
  output logic              dataOverflow
);
  logic [WORD_W-1:0] headWord;
  logic [CMD_W-1:0]  headCmd;
  logic [CCNT_W-1:0] cmdCount;
  logic aboveQ, aboveNow;

  txu_fifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) dataFifo_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .wrEn(dataWrEn), .wrData(dataWrWord),
    .rdEn(strobe.dataPop), .rdData(headWord), .count(dataWordCount)
  );

  txu_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) cmdFifo_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .wrEn(cmdWrEn), .wrData(cmdWrWord),
    .rdEn(strobe.cmdPop), .rdData(headCmd), .count(cmdCount)
  );

  assign status.cmdAvail  = (cmdCount != '0);
  assign status.dataAvail = (dataWordCount != '0);
  assign status.cmdLen    = headCmd[LEN_W-1:0];
  assign status.cmdLane   = headCmd[CMD_W-1:LEN_W];

  assign outByte = headWord[8*strobe.byteSel +: 8];

  assign aboveNow    = (dataWordCount > aeThresh);
  assign almostEmpty = !aboveNow;
  assign aeEvent     = aboveQ && !aboveNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aboveQ       <= 1'b0;
      dataOverflow <= 1'b0;
    end else begin
      aboveQ <= aboveNow;
      if (flush) dataOverflow <= 1'b0;
      else if (dataWrEn && dataWordCount == CNT_W'(DATA_DEPTH)) dataOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/txu_control.sv
module txu_control
  import txu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  txuStatus_t status,
  input  logic       outReady,
  output txuStrobe_t strobe,
  output logic       outValid,
  output logic       outStart,
  output logic       outEnd
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} txuState_e;

  txuState_e         state;
  logic [LEN_W-1:0]  bytesLeft;
  logic [LEN_W-1:0]  wordsLeft;
  logic [LANE_W-1:0] lane;
  logic              firstQ;
  logic              fire, lastByte;
  logic [LEN_W+1:0]  wordSum;

  assign lastByte = (bytesLeft == LEN_W'(1));
  assign wordSum  = {2'b00, status.cmdLen} + (LEN_W+2)'(status.cmdLane) + (LEN_W+2)'(3);

  always_comb begin
    strobe = '0;
    strobe.byteSel = lane;
    outValid = 1'b0;
    fire = 1'b0;
    case (state)
      ST_IDLE:  strobe.cmdPop = status.cmdAvail;
      ST_RUN: begin
        outValid = status.dataAvail;
        fire = outValid && outReady;
        strobe.dataPop = fire && (lastByte || lane == '1);
      end
      ST_DRAIN: strobe.dataPop = status.dataAvail && (wordsLeft != '0);
      default: ;
    endcase
  end

  assign outStart = (state == ST_RUN) && firstQ;
  assign outEnd   = (state == ST_RUN) && lastByte;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      state     <= ST_IDLE;
      bytesLeft <= '0;
      wordsLeft <= '0;
      lane      <= '0;
      firstQ    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (status.cmdAvail) begin
          lane      <= status.cmdLane;
          bytesLeft <= status.cmdLen;
          wordsLeft <= wordSum[LEN_W+1:2];
          firstQ    <= 1'b1;
          state     <= (status.cmdLen == '0) ? ST_DRAIN : ST_RUN;
        end
        ST_RUN: if (fire) begin
          lane      <= lane + 1'b1;
          bytesLeft <= bytesLeft - 1'b1;
          firstQ    <= 1'b0;
          if (strobe.dataPop) wordsLeft <= wordsLeft - 1'b1;
          if (lastByte) state <= ST_IDLE;
        end
        ST_DRAIN: begin
          if (strobe.dataPop) wordsLeft <= wordsLeft - 1'b1;
          if (wordsLeft == '0) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_unpacker.sv
module tx_frame_unpacker
  import txu_pkg::*;
#(
  parameter int DATA_DEPTH = 1024,
  parameter int CMD_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            flush,
  input  logic                            dataWrEn,
  input  logic [31:0]                     dataWrWord,
  input  logic                            cmdWrEn,
  input  logic [17:0]                     cmdWrWord,
  input  logic [$clog2(DATA_DEPTH+1)-1:0] aeThresh,
  output logic [$clog2(DATA_DEPTH+1)-1:0] dataWordCount,
  output logic                            almostEmpty,
  output logic                            aeEvent,
  output logic                            dataOverflow,
  output logic                            outValid,
  input  logic                            outReady,
  output logic [7:0]                      outByte,
  output logic                            outStart,
  output logic                            outEnd
);
  txuStrobe_t strobe;
  txuStatus_t status;

  txu_datapath #(.DATA_DEPTH(DATA_DEPTH), .CMD_DEPTH(CMD_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dataWrEn(dataWrEn), .dataWrWord(dataWrWord),
    .cmdWrEn(cmdWrEn), .cmdWrWord(cmdWrWord),
    .aeThresh(aeThresh), .strobe(strobe), .status(status),
    .outByte(outByte), .dataWordCount(dataWordCount),
    .almostEmpty(almostEmpty), .aeEvent(aeEvent), .dataOverflow(dataOverflow)
  );

  txu_control ctl_i (
    .clk(clk), .rstN(rstN), .flush(flush), .status(status),
    .outReady(outReady), .strobe(strobe),
    .outValid(outValid), .outStart(outStart), .outEnd(outEnd)
  );
endmodule

// File: rtl/txu_checker.sv
module txu_checker #(
  parameter int DATA_DEPTH = 1024,
  localparam int CNT_W = $clog2(DATA_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             dataWrEn,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outByte,
  input logic             outStart,
  input logic             outEnd,
  input logic [CNT_W-1:0] dataWordCount,
  input logic             almostEmpty,
  input logic             aeEvent,
  input logic             dataOverflow
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=> (outValid && $stable(outByte) && $stable(outStart) && $stable(outEnd))); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    dataWordCount <= CNT_W'(DATA_DEPTH)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> ((int'(dataWordCount) <= int'($past(dataWordCount)) + 1) &&
                (int'(dataWordCount) + 1 >= int'($past(dataWordCount))))); // R7
  AST_EVENT_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    aeEvent |-> almostEmpty); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrEn && !flush && dataWordCount == CNT_W'(DATA_DEPTH)) |=> dataOverflow); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (dataOverflow && !flush) |=> dataOverflow); // R9
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!outValid && dataWordCount == '0 && !dataOverflow)); // R10
endmodule

bind tx_frame_unpacker txu_checker #(.DATA_DEPTH(DATA_DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .flush(flush), .dataWrEn(dataWrEn),
  .outValid(outValid), .outReady(outReady), .outByte(outByte),
  .outStart(outStart), .outEnd(outEnd), .dataWordCount(dataWordCount),
  .almostEmpty(almostEmpty), .aeEvent(aeEvent), .dataOverflow(dataOverflow)
);

// File: tb/tx_frame_unpacker_tb_top.sv
`timescale 1ns/100ps
module tx_frame_unpacker_tb_top;
  localparam int DD = 16;
  localparam int CD = 4;
  localparam int CW = $clog2(DD + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic dataWrEn = 1'b0;
  logic [31:0] dataWrWord = '0;
  logic cmdWrEn = 1'b0;
  logic [17:0] cmdWrWord = '0;
  logic [CW-1:0] aeThresh = CW'(4);
  logic [CW-1:0] dataWordCount;
  logic almostEmpty, aeEvent, dataOverflow;
  logic outValid;
  logic outReady = 1'b0;
  logic [7:0] outByte;
  logic outStart, outEnd;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int aeEvents = 0;
  int validSeen = 0;

  always #2 clk = ~clk;

  tx_frame_unpacker #(.DATA_DEPTH(DD), .CMD_DEPTH(CD)) dut_i (.*);

  always @(negedge clk) begin
    if (rstN && aeEvent) aeEvents++;
    if (rstN && outValid) validSeen++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int seed, input int i);
    return 8'((seed * 13 + i * 29 + 7) & 255);
  endfunction

  function automatic int nWords(input int len, input int lane);
    return (len + lane + 3) / 4;
  endfunction

  task automatic pushWord(input logic [31:0] w);
    dataWrEn = 1'b1;
    dataWrWord = w;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic pushCmd(input int len, input int lane);
    cmdWrEn = 1'b1;
    cmdWrWord = {2'(lane), 16'(len)};
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic pushData(input int len, input int lane, input int seed);
    for (int w = 0; w < nWords(len, lane); w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) begin
        int idx = w * 4 + b - lane;
        word[8*b +: 8] = (idx >= 0 && idx < len) ? expByte(seed, idx) : 8'(8'hE0 | b);
      end
      pushWord(word);
    end
  endtask

  task automatic recvFrame(input int len, input int seed);
    int got = 0;
    int waitc = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    while (got < len && waitc < 3000) begin
      outReady = ((waitc % 3) != 2);
      #1;
      if (outValid) begin
        if (stalled) chk(outByte == held, "R4", "held byte", outByte, held);
        if (outReady) begin
          chk(outByte == expByte(seed, got), "R2", "byte", outByte, expByte(seed, got));
          chk(outStart == (got == 0), "R3", "start", outStart, got == 0);
          chk(outEnd == (got == len - 1), "R3", "end", outEnd, got == len - 1);
          got++;
          stalled = 0;
        end else begin
          stalled = 1;
          held = outByte;
        end
      end
      waitc++;
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(got == len, "R2", "byte total", got, len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(dataWordCount == 0, "R11", "count", dataWordCount, 0);
    chk(!outValid, "R11", "valid", outValid, 0);
    chk(!dataOverflow, "R11", "overflow", dataOverflow, 0);
    chk(almostEmpty, "R11", "almostEmpty", almostEmpty, 1);

    // R1 R2 R3: sweep all lanes against lengths 1..13
    for (int lane = 0; lane < 4; lane++) begin
      for (int len = 1; len <= 13; len++) begin
        int seed = lane * 16 + len;
        pushData(len, lane, seed);
        pushCmd(len, lane);
        chk(dataWordCount == CW'(nWords(len, lane)), "R1", "words held", dataWordCount, nWords(len, lane));
        recvFrame(len, seed);
        chk(dataWordCount == 0, "R1", "words left", dataWordCount, 0);
      end
    end

    // R5: data without command stays silent, then queued frames keep order
    pushData(5, 3, 101);
    validSeen = 0;
    repeat (8) @(negedge clk);
    chk(validSeen == 0, "R5", "valid before cmd", validSeen, 0);
    pushCmd(5, 3);
    pushData(6, 1, 102);
    pushCmd(6, 1);
    recvFrame(5, 101);
    recvFrame(6, 102);
    chk(dataWordCount == 0, "R5", "count after pair", dataWordCount, 0);

    // R6: zero-length command consumes its word
    pushData(0, 2, 0);
    pushWord(32'hDEAD_BEEF);
    validSeen = 0;
    chk(dataWordCount == 2, "R6", "count before", dataWordCount, 2);
    pushCmd(0, 2);
    repeat (6) @(negedge clk);
    chk(validSeen == 0, "R6", "no bytes", validSeen, 0);
    chk(dataWordCount == 1, "R6", "one word consumed", dataWordCount, 1);
    flush = 1'b1; @(negedge clk); flush = 1'b0;

    // R8: threshold 4, six words drained
    pushData(24, 0, 55);
    chk(dataWordCount == 6, "R7", "count six", dataWordCount, 6);
    chk(!almostEmpty, "R8", "above thr", almostEmpty, 0);
    aeEvents = 0;
    pushCmd(24, 0);
    recvFrame(24, 55);
    chk(aeEvents == 1, "R8", "event pulses", aeEvents, 1);
    chk(almostEmpty, "R8", "below thr", almostEmpty, 1);

    // R9: overflow
    for (int i = 0; i < DD; i++) pushWord(32'(i));
    chk(dataWordCount == DD, "R9", "full count", dataWordCount, DD);
    chk(!dataOverflow, "R9", "no ovf yet", dataOverflow, 0);
    pushWord(32'hFFFF_FFFF);
    chk(dataWordCount == DD, "R9", "count held", dataWordCount, DD);
    chk(dataOverflow, "R9", "ovf set", dataOverflow, 1);
    repeat (3) @(negedge clk);
    chk(dataOverflow, "R9", "ovf sticky", dataOverflow, 1);

    // R10: flush clears all, then mid-frame abandon
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    chk(dataWordCount == 0, "R10", "count", dataWordCount, 0);
    chk(!dataOverflow, "R10", "ovf clear", dataOverflow, 0);
    pushData(8, 1, 77);
    pushCmd(8, 1);
    @(negedge clk);
    chk(outValid, "R10", "frame pending", outValid, 1);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    chk(!outValid, "R10", "valid dropped", outValid, 0);
    chk(dataWordCount == 0, "R10", "count after", dataWordCount, 0);
    pushData(7, 2, 88);
    pushCmd(7, 2);
    recvFrame(7, 88);
    chk(dataWordCount == 0, "R10", "clean restart", dataWordCount, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule